// File: doc/BRIEF.md
# Byte-Lane Hamming Single-Error Corrector

This block guards a 16-bit data path with an independent single-error-correcting code on each 8-bit byte lane. On the write side it turns each data byte into 4 check bits that are stored next to the byte. On the read side it takes each stored byte with its 4 check bits, forms a syndrome, and repairs any one flipped bit among the 12 stored bits. The caller therefore sees the same 16-bit value that was written, as if the storage had no protection at all.

Both paths are purely combinational and the two lanes share nothing. A lane whose syndrome can only come from a multi-bit upset passes its byte through untouched and flags it as uncorrectable. There is no double-error detection and no extra overall parity bit, so some double errors are silently miscorrected.

Top module: `byte_lane_ecc`

## Requirements
- R1: In each lane's 12-bit code word, check bit j (j = 0..3) sits at position 2^j (positions 1, 2, 4, 8) and data bits 0..7 fill positions 3, 5, 6, 7, 9, 10, 11, 12 in that ascending order. Check bit j is the even parity of every data position whose index has bit j set. Lane L's check bits are `wr_chk_o[4L+3:4L]`, bit j of that slice being check bit j.
- R2: Lane 0 uses data bits [7:0] with check bits [3:0], lane 1 uses data bits [15:8] with check bits [7:4]; an error in one lane never changes the other lane's outputs or flags.
- R3: A code word read back exactly as written yields the original byte with both the corrected and uncorrectable flags low.
- R4: A single flipped data bit in a lane is inverted back, giving the original byte, with the lane's corrected flag high and uncorrectable flag low.
- R5: A single flipped check bit leaves the data output equal to the input byte and raises the corrected flag.
- R6: A syndrome of 13, 14 or 15 leaves the lane's data output equal to its data input, raises the uncorrectable flag and keeps the corrected flag low.
- R7: The corrected and uncorrectable flags of a lane are never high together, and a correction changes at most one data bit.
- R8: All outputs are combinational functions of the present inputs, with no clock or storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data_i | input | 16 | Data to be stored, two byte lanes |
| wr_chk_o | output | 8 | Check bits for the stored data, 4 per lane |
| rd_data_i | input | 16 | Data read back from storage |
| rd_chk_i | input | 8 | Check bits read back from storage |
| rd_data_o | output | 16 | Corrected read data |
| corrected_o | output | 2 | Per-lane flag: one bit was repaired |
| uncorrectable_o | output | 2 | Per-lane flag: syndrome out of range, data passed unchanged |

## Verification
Every one of the 256 byte values is encoded and compared with an independently built code word, then read back clean and with each of the 12 single-bit errors; clean reads separate a correct encoder from a misplaced parity mask, data-bit errors expose a wrong position map, and check-bit errors show the data is left alone. Lane 1 is driven with a different byte and a different error position from lane 0 in the same cycle, so any crosstalk between lanes shows. Chosen two-bit errors whose syndromes land on 13, 14 and 15 show the out-of-range path passes the byte unchanged and raises only the uncorrectable flag.

// File: rtl/hamming_pkg.sv
package hamming_pkg;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // code position (1-based) of data bit k: k-th index that is not a power of two
  function automatic int data_pos(input int k);
    int n;
    n = 0;
    for (int p = 1; p < 256; p++) begin
      if (!is_pow2(p)) begin
        if (n == k) return p;
        n++;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/ham_enc.sv
module ham_enc #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  import hamming_pkg::*;
  localparam int CODE_W = DATA_W + CHK_W;

  logic [CODE_W-1:0] code;

  always_comb begin
    code = '0;
    for (int k = 0; k < DATA_W; k++) code[data_pos(k)-1] = data_i[k];
    for (int j = 0; j < CHK_W; j++) begin
      chk_o[j] = 1'b0;
      for (int p = 1; p <= CODE_W; p++)
        if (((p >> j) & 1) == 1) chk_o[j] = chk_o[j] ^ code[p-1];
    end
  end

endmodule

// File: rtl/ham_dec.sv
module ham_dec #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corrected_o,
  output logic              uncorr_o
);
  import hamming_pkg::*;
  localparam int CODE_W = DATA_W + CHK_W;

  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] fixed;
  logic [CHK_W-1:0]  syn;

  always_comb begin
    code = '0;
    for (int k = 0; k < DATA_W; k++) code[data_pos(k)-1] = data_i[k];
    for (int j = 0; j < CHK_W; j++) code[(1 << j)-1] = chk_i[j];
    for (int j = 0; j < CHK_W; j++) begin
      syn[j] = 1'b0;
      for (int p = 1; p <= CODE_W; p++)
        if (((p >> j) & 1) == 1) syn[j] = syn[j] ^ code[p-1];
    end
  end

  // flip the named position only when the syndrome points inside the word
  always_comb begin
    fixed = code;
    for (int p = 1; p <= CODE_W; p++)
      if (int'(syn) == p) fixed[p-1] = ~code[p-1];
    for (int k = 0; k < DATA_W; k++) data_o[k] = fixed[data_pos(k)-1];
    corrected_o = (syn != '0) && (int'(syn) <= CODE_W);
    uncorr_o    = int'(syn) > CODE_W;
  end

  always_comb begin
    a_r7_flags_exclusive: assert (!(corrected_o && uncorr_o))
      else $error("R7: both flags high");
    a_r7_one_bit_fix: assert ($countones(data_o ^ data_i) <= 1)
      else $error("R7: more than one data bit changed");
    a_r6_uncorr_passthru: assert (!uncorr_o || (data_o == data_i))
      else $error("R6: data altered on uncorrectable syndrome");
    a_r3_clean_passthru: assert (corrected_o || uncorr_o || (data_o == data_i))
      else $error("R3: data altered without a flag");
  end

endmodule

// File: rtl/byte_lane_ecc.sv
module byte_lane_ecc #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4
) (
  input  logic [LANES*DATA_W-1:0] wr_data_i,
  output logic [LANES*CHK_W-1:0]  wr_chk_o,
  input  logic [LANES*DATA_W-1:0] rd_data_i,
  input  logic [LANES*CHK_W-1:0]  rd_chk_i,
  output logic [LANES*DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]        corrected_o,
  output logic [LANES-1:0]        uncorrectable_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ham_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data_i (wr_data_i[l*DATA_W +: DATA_W]),
      .chk_o  (wr_chk_o[l*CHK_W +: CHK_W])
    );
    ham_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .data_i      (rd_data_i[l*DATA_W +: DATA_W]),
      .chk_i       (rd_chk_i[l*CHK_W +: CHK_W]),
      .data_o      (rd_data_o[l*DATA_W +: DATA_W]),
      .corrected_o (corrected_o[l]),
      .uncorr_o    (uncorrectable_o[l])
    );

    // encoder and decoder are separate logic: a fresh code word must decode clean
    always_comb begin
      a_r3_roundtrip: assert (!((rd_data_i[l*DATA_W +: DATA_W] == wr_data_i[l*DATA_W +: DATA_W]) &&
                                (rd_chk_i[l*CHK_W +: CHK_W] == wr_chk_o[l*CHK_W +: CHK_W]) &&
                                (corrected_o[l] || uncorrectable_o[l])))
        else $error("R3: flag raised on freshly encoded word");
    end
  end

endmodule

// File: tb/tb_byte_lane_ecc.sv
module tb_byte_lane_ecc;
  logic        clk = 1'b0;
  logic [15:0] wr_data, rd_data, rd_dout;
  logic [7:0]  wr_chk, rd_chk;
  logic [1:0]  corr, uncorr;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  byte_lane_ecc dut (
    .wr_data_i(wr_data), .wr_chk_o(wr_chk), .rd_data_i(rd_data), .rd_chk_i(rd_chk),
    .rd_data_o(rd_dout), .corrected_o(corr), .uncorrectable_o(uncorr)
  );

  int dpos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  // reference code word, bit p-1 holds position p
  function automatic logic [11:0] mk_code(input logic [7:0] d);
    logic [11:0] c;
    c = '0;
    foreach (dpos[k]) c[dpos[k]-1] = d[k];
    for (int j = 0; j < 4; j++) begin
      int ones;
      ones = 0;
      foreach (dpos[k]) if ((dpos[k] & (1 << j)) != 0 && d[k]) ones++;
      c[(1 << j)-1] = ones[0];
    end
    return c;
  endfunction

  function automatic logic [7:0] c_data(input logic [11:0] c);
    logic [7:0] d;
    foreach (dpos[k]) d[k] = c[dpos[k]-1];
    return d;
  endfunction

  function automatic logic [3:0] c_chk(input logic [11:0] c);
    return {c[7], c[3], c[1], c[0]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lane codes plus error masks; exp_d / exp_f are expected data and flags {uncorr,corr}
  task automatic apply(input logic [7:0] d0, input logic [11:0] e0, input logic [7:0] x0, input logic [1:0] f0,
                       input logic [7:0] d1, input logic [11:0] e1, input logic [7:0] x1, input logic [1:0] f1,
                       input string req);
    logic [11:0] c0, c1;
    @(posedge clk);
    c0 = mk_code(d0);
    c1 = mk_code(d1);
    wr_data = {d1, d0};
    rd_data = {c_data(c1 ^ e1), c_data(c0 ^ e0)};
    rd_chk  = {c_chk(c1 ^ e1), c_chk(c0 ^ e0)};
    @(negedge clk);
    check("R1 lane0 check bits", int'(wr_chk[3:0]), int'(c_chk(c0)));
    check("R1 lane1 check bits", int'(wr_chk[7:4]), int'(c_chk(c1)));
    check({req, " lane0 data"}, int'(rd_dout[7:0]), int'(x0));
    check({req, " lane0 flags"}, int'({uncorr[0], corr[0]}), int'(f0));
    check({"R2 ", req, " lane1 data"}, int'(rd_dout[15:8]), int'(x1));
    check({"R2 ", req, " lane1 flags"}, int'({uncorr[1], corr[1]}), int'(f1));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wr_data = '0; rd_data = '0; rd_chk = '0;
    #1;
    // R8: all-zero inputs settle combinationally to a clean result
    check("R8 idle data", int'(rd_dout), 0);
    check("R8 idle flags", int'({uncorr, corr}), 0);
    check("R1 idle check bits", int'(wr_chk), 0);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] d0, d1;
      d0 = v[7:0];
      d1 = d0 ^ 8'hA5;
      // R3 clean in both lanes
      apply(d0, 12'h0, d0, 2'b00, d1, 12'h0, d1, 2'b00, "R3 clean");
      for (int p = 1; p <= 12; p++) begin
        int q;
        bit chk_pos;
        q = ((p + 4) % 12) + 1;
        chk_pos = (p == 1) || (p == 2) || (p == 4) || (p == 8);
        apply(d0, 12'(1) << (p-1), d0, 2'b01,
              d1, 12'(1) << (q-1), d1, 2'b01,
              chk_pos ? "R5 check-bit flip" : "R4 data-bit flip");
      end
      // R2: error only in lane 0, lane 1 clean
      apply(d0, 12'(1) << 8, d0, 2'b01, d1, 12'h0, d1, 2'b00, "R2 isolated");
    end

    // R6: two-bit errors with syndromes 13 (5^8), 14 (7^9), 15 (3^12), 13 (6^11)
    for (int v = 0; v < 256; v += 17) begin
      logic [7:0] d;
      logic [11:0] m[4];
      d = v[7:0];
      m[0] = (12'(1) << 4) | (12'(1) << 7);
      m[1] = (12'(1) << 6) | (12'(1) << 8);
      m[2] = (12'(1) << 2) | (12'(1) << 11);
      m[3] = (12'(1) << 5) | (12'(1) << 10);
      for (int i = 0; i < 4; i++) begin
        logic [7:0] bad_d;
        bad_d = c_data(mk_code(d) ^ m[i]);
        apply(d, m[i], bad_d, 2'b10, ~d, m[(i+1)%4], c_data(mk_code(~d) ^ m[(i+1)%4]), 2'b10,
              "R6 R7 out-of-range syndrome");
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule